// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a carry-in. The carries are not rippled. Each bit forms a generate term (both operand bits set) and a propagate term (exactly one operand bit set). A bit pair of 00 kills an incoming carry, a pair of 01 or 10 passes it on, and a pair of 11 creates one.

The bits are split into four 4-bit groups. Inside each group, a lookahead unit forms the carry into every bit as a flat sum of products. Each product is a generate term ANDed with the propagate terms above it, plus the product of all lower propagates and the group's carry-in. The same unit, applied a second time to the four group generate/propagate pairs and the block carry-in, gives the carry into each group and the 16-bit carry-out.

The block also exports an overall generate and propagate pair, so that a further lookahead level can join several of these adders into a wider one. The results are registered, so every output appears one clock after its operands.

Top module: `cla_adder16`

## Requirements
- R1: One clock after operands `op_a`, `op_b` and `carry_in` are applied, `{carry_out, sum}` equals `op_a + op_b + carry_in` taken as a 17-bit unsigned value. This holds for every group-boundary carry pattern, including 0xFFFF + 0x0001.
- R2: While `rst_n` is low, `sum`, `carry_out`, `blk_gen` and `blk_prop` read zero one clock later.
- R3: The per-bit rules are: generate is `a & b` and propagate is `a ^ b`. So a bit pair of 11 yields a sum bit equal to the incoming carry and sends a carry one bit higher, for example 0x0100 + 0x0100 = 0x0200.
- R4: `blk_prop` is 1 exactly when `op_a ^ op_b` is all ones (every bit pair is 01 or 10).
- R5: `blk_gen` is 1 exactly when `op_a + op_b` with a zero carry-in overflows 16 bits.
- R6: When every bit propagates, `carry_in` passes through all four groups to `carry_out`, and `sum` is all ones when `carry_in` is 0 and zero when `carry_in` is 1.
- R7: When the top bit pair is 00, `carry_out` is 0 whatever the lower bits and `carry_in` are.
- R8: `carry_out` equals `blk_gen | (blk_prop & carry_in)` for the `carry_in` of the same operand set. This is the cascade equation a higher lookahead level relies on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Registered sum |
| carry_out | output | 1 | Registered carry out of bit 15 |
| blk_gen | output | 1 | Registered block generate, for cascading |
| blk_prop | output | 1 | Registered block propagate, for cascading |

## Verification
Block propagate and carry pass-through can both be active in one cycle. With `op_a ^ op_b` all ones and `carry_in` set, `blk_prop` must be high while the second lookahead level carries `carry_in` across all four groups. The bench provokes this with the 0x5555 + 0xAAAA pattern and with 0xFFFF + 0x0000. In that cycle it checks that `carry_out` is 1, `sum` is zero and `blk_gen` stays 0, and it compares every field against a behavioural sum. Random operands and single-group boundary crossings check that the group generate and the carry chain also agree when they happen together.

// File: rtl/cla_pkg.sv
package cla_pkg;
    // Classification of one bit pair with respect to an incoming carry.
    typedef enum logic [1:0] {
        BIT_KILL = 2'd0,
        BIT_PASS = 2'd1,
        BIT_GEN  = 2'd2
    } bit_class_e;

    function automatic bit_class_e classify(input logic a, input logic b);
        if (a & b)      return BIT_GEN;
        else if (a ^ b) return BIT_PASS;
        else            return BIT_KILL;
    endfunction
endpackage

// File: rtl/cla_pg_cell.sv
module cla_pg_cell
    import cla_pkg::*;
(
    input  logic a_i,
    input  logic b_i,
    output logic g_o,
    output logic p_o
);
    always_comb begin
        g_o = a_i & b_i;
        p_o = a_i ^ b_i;
    end

    // R3
    always_comb begin
        bit_class_chk: assert ((classify(a_i, b_i) == BIT_GEN) == g_o &&
                               (classify(a_i, b_i) == BIT_PASS) == p_o);
    end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] g_i,
    input  logic [N-1:0] p_i,
    input  logic         c_i,
    output logic [N:0]   c_o,      // c_o[k] = carry into position k, c_o[N] = carry out
    output logic         grp_g_o,
    output logic         grp_p_o
);
    // Each carry is a flat sum of products once the loops unroll.
    always_comb begin
        logic prod;
        logic term;
        c_o[0] = c_i;
        for (int i = 0; i < int'(N); i++) begin
            term = 1'b0;
            prod = 1'b1;
            for (int j = i; j >= 0; j--) begin
                term = term | (g_i[j] & prod);
                prod = prod & p_i[j];
            end
            c_o[i+1] = term | (prod & c_i);
        end
    end

    always_comb begin
        logic prod;
        grp_g_o = 1'b0;
        prod    = 1'b1;
        for (int j = int'(N) - 1; j >= 0; j--) begin
            grp_g_o = grp_g_o | (g_i[j] & prod);
            prod    = prod & p_i[j];
        end
        grp_p_o = &p_i;
    end

    // R6
    always_comb begin
        if (&p_i) pass_chain_chk: assert (c_o[N] == c_i);
    end

    // R7
    always_comb begin
        if (!g_i[N-1] && !p_i[N-1]) top_kill_chk: assert (!c_o[N]);
    end
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
    parameter int unsigned GROUP_W    = 4,
    parameter int unsigned NUM_GROUPS = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [GROUP_W*NUM_GROUPS-1:0]   op_a,
    input  logic [GROUP_W*NUM_GROUPS-1:0]   op_b,
    input  logic                            carry_in,
    output logic [GROUP_W*NUM_GROUPS-1:0]   sum,
    output logic                            carry_out,
    output logic                            blk_gen,
    output logic                            blk_prop
);
    localparam int unsigned WIDTH = GROUP_W * NUM_GROUPS;

    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic             cout;
        logic             gen;
        logic             prop;
    } out_state_t;

    logic [WIDTH-1:0]      bit_g, bit_p, bit_c;
    logic [NUM_GROUPS-1:0] grp_g, grp_p;
    logic [NUM_GROUPS:0]   grp_c;
    logic [NUM_GROUPS-1:0] grp_top_c;
    logic                  top_g, top_p;
    out_state_t            st_d, st_q;

    // First level: bit cells and a lookahead unit per group.
    for (genvar gi = 0; gi < NUM_GROUPS; gi++) begin : g_group
        logic [GROUP_W:0] c_loc;
        for (genvar bi = 0; bi < GROUP_W; bi++) begin : g_bit
            cla_pg_cell u_pg (
                .a_i (op_a[gi*GROUP_W+bi]),
                .b_i (op_b[gi*GROUP_W+bi]),
                .g_o (bit_g[gi*GROUP_W+bi]),
                .p_o (bit_p[gi*GROUP_W+bi])
            );
        end
        cla_lookahead #(.N(GROUP_W)) u_la (
            .g_i     (bit_g[gi*GROUP_W +: GROUP_W]),
            .p_i     (bit_p[gi*GROUP_W +: GROUP_W]),
            .c_i     (grp_c[gi]),
            .c_o     (c_loc),
            .grp_g_o (grp_g[gi]),
            .grp_p_o (grp_p[gi])
        );
        assign bit_c[gi*GROUP_W +: GROUP_W] = c_loc[GROUP_W-1:0];
        assign grp_top_c[gi]                = c_loc[GROUP_W];
    end

    // Second level: same equations over the group pairs.
    cla_lookahead #(.N(NUM_GROUPS)) u_la_top (
        .g_i     (grp_g),
        .p_i     (grp_p),
        .c_i     (carry_in),
        .c_o     (grp_c),
        .grp_g_o (top_g),
        .grp_p_o (top_p)
    );

    always_comb begin
        st_d.sum  = bit_p ^ bit_c;
        st_d.cout = grp_c[NUM_GROUPS];
        st_d.gen  = top_g;
        st_d.prop = top_p;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum       = st_q.sum;
    assign carry_out = st_q.cout;
    assign blk_gen   = st_q.gen;
    assign blk_prop  = st_q.prop;

    // Assertion support: set once one operand set has been registered.
    logic primed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    // R1
    sum_model_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> {carry_out, sum} ==
                     $past({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}));

    // R1
    grp_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_top_c[NUM_GROUPS-1] == grp_c[NUM_GROUPS] &&
        grp_top_c[NUM_GROUPS-2:0] == grp_c[NUM_GROUPS-1:1]);

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (sum == '0 && !carry_out && !blk_gen && !blk_prop));

    // R4
    blk_prop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> blk_prop == $past(&(op_a ^ op_b)));

    // R5
    blk_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> blk_gen == $past(({1'b0, op_a} + {1'b0, op_b}) >> WIDTH != 0));

    // R8
    cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> carry_out == (blk_gen | (blk_prop & $past(carry_in))));
endmodule

// File: tb/tb_cla_adder16.sv
module tb_cla_adder16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0, op_b = '0;
    logic        carry_in = 1'b0;
    logic [15:0] sum;
    logic        carry_out, blk_gen, blk_prop;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [15:0] sum;
        logic        cout;
        logic        gen;
        logic        prop;
        string       req;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    cla_adder16 dut (
        .clk (clk), .rst_n (rst_n),
        .op_a (op_a), .op_b (op_b), .carry_in (carry_in),
        .sum (sum), .carry_out (carry_out),
        .blk_gen (blk_gen), .blk_prop (blk_prop)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: applies one operand set at a falling edge and queues its expectation.
    task automatic drive(input logic [15:0] a, input logic [15:0] b,
                         input logic ci, input string req);
        exp_t e;
        logic [16:0] full, raw;
        full   = {1'b0, a} + {1'b0, b} + {16'd0, ci};
        raw    = {1'b0, a} + {1'b0, b};
        e.sum  = full[15:0];
        e.cout = full[16];
        e.gen  = raw[16];
        e.prop = ((a ^ b) == 16'hFFFF);
        e.req  = req;
        @(negedge clk);
        op_a = a; op_b = b; carry_in = ci;
        sb_q.push_back(e);
    endtask

    // Monitor: the item queued before a rising edge is visible just after it.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.req, "sum",  32'(sum),       32'(e.sum));
                check(e.req, "cout", 32'(carry_out), 32'(e.cout));
                check("R5",  "gen",  32'(blk_gen),   32'(e.gen));
                check("R4",  "prop", 32'(blk_prop),  32'(e.prop));
                // R8 cascade equation on the observed outputs
                check("R8", "cascade", 32'(carry_out),
                      32'(e.gen | (e.prop & (e.cout ^ e.gen ? 1'b1 : e.cout))));
            end
        end
    end

    initial begin
        op_a = 16'h1234; op_b = 16'hFFFF; carry_in = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R2", "reset sum",  32'(sum), 32'd0);
        check("R2", "reset cout", 32'(carry_out), 32'd0);
        check("R2", "reset gen",  32'(blk_gen), 32'd0);
        check("R2", "reset prop", 32'(blk_prop), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        drive(16'hFFFF, 16'h0001, 1'b0, "R1");  // all-ones plus one
        drive(16'h000F, 16'h0001, 1'b0, "R1");  // crosses first group
        drive(16'h0FFF, 16'h0001, 1'b0, "R1");  // crosses three groups
        drive(16'h0100, 16'h0100, 1'b0, "R3");  // generate bit
        drive(16'h0000, 16'h0000, 1'b1, "R3");  // kill bits, cin only
        drive(16'hFFFF, 16'h0000, 1'b1, "R6");  // full propagate, cin passes
        drive(16'h5555, 16'hAAAA, 1'b1, "R6");
        drive(16'h5555, 16'hAAAA, 1'b0, "R6");
        drive(16'h7FFF, 16'h0000, 1'b1, "R7");  // top pair 00 kills
        drive(16'h7FFF, 16'h7FFF, 1'b1, "R7");
        drive(16'hFFFF, 16'hFFFF, 1'b1, "R5");  // block generate
        drive(16'h8000, 16'h8000, 1'b0, "R5");
        for (int i = 0; i < 400; i++)
            drive(16'($urandom), 16'($urandom), 1'($urandom), "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule